// File: doc/BRIEF.md
# Indexed-register ADC host interface

This block sits between a host byte bus and a single 12-bit successive-approximation converter fed by an analogue input multiplexer. The host sees four byte addresses: a write-only index register, a control/status port, and the low and high bytes of the conversion result. Internal registers are reached indirectly. The host writes an index, then reads or writes the control/status port. The multiplexer channel select is one such register.

A conversion can be started from three sources: a software write sequence, an external logic-level pulse, or a periodic tick from a timer. A static select input chooses the source. The block drives the channel select to the multiplexer. It runs a behavioural model of the converter handshake: start, then busy for a fixed number of cycles, then done with data captured from the `sample` input. The 12-bit result is held for byte-wise readback. A trigger that arrives while the converter is busy is dropped and recorded in a sticky overrun flag. Reading the low byte freezes the high byte, so the two halves always come from one conversion.

Top module: `adc_index_port`

## Requirements
- R1: At offset 0 the bus writes the index register, and reads return 00H. When the index holds 01H, a write to offset 1 loads the channel select, and a read of offset 1 returns it right-aligned. Both are 00H after reset.
- R2: The channel select keeps only its low log2(CHANNELS) bits (CHANNELS is 8 or 16) and drives `mux_sel` directly.
- R3: With `trig_sel`=0 (software), a write of 00H to offset 0 starts a conversion only when the index currently holds 01H. A 00H write while the index already holds 00H starts nothing.
- R4: With `trig_sel`=1 (external), `ext_trig` passes through a two-flop synchroniser and a rising-edge detector. Busy becomes visible three clock edges after the input rises, and each pulse, however long, starts exactly one conversion.
- R5: With `trig_sel`=2 (timer), a one-cycle `timer_tick` starts a conversion, and busy is visible after the next edge. Sources that are not selected have no effect. Value 3 selects no source.
- R6: After a start, busy reads 1 for exactly CONV_CYCLES cycles. Then busy reads 0, done reads 1, and the result holds the value of `sample` taken on the final cycle.
- R7: When the index holds 00H, a read of offset 1 returns status: bit 7 busy, bit 6 done, bit 5 overrun, and bits 4..0 zero.
- R8: A trigger from the selected source while busy is ignored and sets the overrun flag. The flag clears on a status read. If a new overrun arrives in the same cycle as the read, the flag stays set.
- R9: Offset 2 reads result bits 7..0. Offset 3 reads 0000b in bits 7..4 and the held result bits 11..8 in bits 3..0.
- R10: A read of offset 2 copies result bits 11..8 into the high-byte hold. A later conversion does not change what offset 3 returns until the next low read. A read of offset 3 clears done.
- R11: Writes to offsets 2 and 3 change neither the result nor any readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally in the strobe cycle |
| trig_sel | input | 2 | Trigger source: 0 software, 1 external, 2 timer, 3 none |
| ext_trig | input | 1 | Asynchronous external trigger pulse |
| timer_tick | input | 1 | Periodic one-cycle tick from a timer |
| mux_sel | output | $clog2(CHANNELS) | Analogue multiplexer channel select |
| sample | input | 12 | Converter output value for the selected channel |

## Verification
The hardest case to reach is the torn read. A conversion has to complete, with a different high nibble, in the gap between the host reading the low byte and reading the high byte. The bench reaches it by reading the low byte of one result, then selecting another channel, starting a second conversion and waiting for busy to fall before it reads the high byte. The bench's sample source is a function of `mux_sel`, so each channel gives a distinct nibble. The overrun case is reached by writing the software trigger sequence again while a conversion is still running.

// File: rtl/adc_index_port.sv
module adc_index_port #(
  parameter int CHANNELS    = 16,
  parameter int CONV_CYCLES = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic [1:0]                  trig_sel,
  input  logic                        ext_trig,
  input  logic                        timer_tick,
  output logic [$clog2(CHANNELS)-1:0] mux_sel,
  input  logic [11:0]                 sample
);
  localparam int CH_W  = $clog2(CHANNELS);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [7:0] IDX_STAT = 8'h00;
  localparam logic [7:0] IDX_CHAN = 8'h01;

  logic [7:0]       idx;
  logic [CH_W-1:0]  chan;
  logic [2:0]       ext_sync;
  logic             busy, done, ovr;
  logic [CNT_W-1:0] cnt;
  logic [11:0]      result;
  logic [3:0]       hi_hold;
  logic             trig;

  wire wr_idx   = bus_wr && bus_addr == 2'd0;
  wire wr_ctl   = bus_wr && bus_addr == 2'd1;
  wire rd_stat  = bus_rd && bus_addr == 2'd1 && idx == IDX_STAT;
  wire rd_lo    = bus_rd && bus_addr == 2'd2;
  wire rd_hi    = bus_rd && bus_addr == 2'd3;
  wire sw_trig  = wr_idx && bus_wdata == IDX_STAT && idx == IDX_CHAN;
  wire ext_rise = ext_sync[1] & ~ext_sync[2];
  wire start    = trig && !busy;
  wire late     = trig && busy;
  wire finish   = busy && cnt == '0;

  always_comb begin
    case (trig_sel)
      2'd0:    trig = sw_trig;
      2'd1:    trig = ext_rise;
      2'd2:    trig = timer_tick;
      default: trig = 1'b0;
    endcase
  end

  assign mux_sel = chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      chan     <= '0;
      ext_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_trig};
      if (wr_idx) idx <= bus_wdata;
      if (wr_ctl && idx == IDX_CHAN) chan <= bus_wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_LAST;
    end else if (finish) begin
      busy   <= 1'b0;
      result <= sample;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      ovr     <= 1'b0;
      hi_hold <= '0;
    end else begin
      if (finish)     done <= 1'b1;
      else if (rd_hi) done <= 1'b0;
      if (late)         ovr <= 1'b1;
      else if (rd_stat) ovr <= 1'b0;
      if (rd_lo) hi_hold <= result[11:8];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      2'd1: begin
        if (idx == IDX_STAT)      bus_rdata = {busy, done, ovr, 5'b0};
        else if (idx == IDX_CHAN) bus_rdata = 8'(chan);
      end
      2'd2:    bus_rdata = result[7:0];
      2'd3:    bus_rdata = {4'b0, hi_hold};
      default: bus_rdata = 8'h00;
    endcase
  end

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!busy && done));
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    late |=> ovr);
  a_r9_hi_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata[7:4] == 4'h0));
  a_r10_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !finish) |=> !done);
  a_r4_one_start_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'd1 && $stable(trig_sel) && ext_rise) |=> !ext_rise);
endmodule

// File: tb/adc_index_port_tb.sv
module adc_index_port_tb;
  localparam int CHANNELS = 16;
  localparam int CONV     = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] trig_sel;
  logic       ext_trig, timer_tick;
  logic [3:0] mux_sel;
  logic [11:0] sample;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  assign sample = {mux_sel, ~mux_sel, mux_sel};

  adc_index_port #(.CHANNELS(CHANNELS), .CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_sel(trig_sel), .ext_trig(ext_trig), .timer_tick(timer_tick),
    .mux_sel(mux_sel), .sample(sample));

  function automatic logic [11:0] exp_sample(input logic [3:0] ch);
    return {ch, ~ch, ch};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4 * CONV; i++) begin
      rd(2'd1, s);
      if (!s[7]) break;
    end
  endtask

  task automatic select_chan(input logic [3:0] ch);
    wr(2'd0, 8'h01);
    wr(2'd1, {4'h0, ch});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd1, d); check("R7 reset status", d, 8'h00);
    rd(2'd0, d); check("R1 index reads zero", d, 8'h00);
    rd(2'd2, d); check("R9 reset low", d, 8'h00);
    rd(2'd3, d); check("R9 reset high", d, 8'h00);
    check("R1 reset channel", mux_sel, 4'h0);
  endtask

  task automatic t_channel();
    logic [7:0] d;
    select_chan(4'h5);
    rd(2'd1, d); check("R1 channel readback", d, 8'h05);
    check("R2 mux_sel", mux_sel, 4'h5);
    wr(2'd1, 8'h1B);
    rd(2'd1, d); check("R2 channel masked", d, 8'h0B);
    wr(2'd1, 8'h05);
  endtask

  task automatic t_sw_conversion();
    logic [7:0] d;
    int busy_n = 0;
    trig_sel = 2'd0;
    wr(2'd0, 8'h00);
    for (int i = 0; i < 2 * CONV; i++) begin
      rd(2'd1, d);
      if (d[7]) busy_n++;
      else break;
    end
    check("R6 busy duration", 12'(busy_n), 12'(CONV));
    check("R7 status done", d, 8'h40);
    rd(2'd2, d); check("R9 low byte", d, {4'h0, exp_sample(4'h5)[7:0]});
    rd(2'd3, d); check("R9 high byte", d, {8'h0, 4'h0, exp_sample(4'h5)[11:8]});
    rd(2'd1, d); check("R10 done cleared", d, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd1, d); check("R3 no start from idle index", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    select_chan(4'h5);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd1, d); check("R8 overrun set while busy", d[7:5], 3'b101);
    rd(2'd1, d); check("R8 overrun cleared by read", d[5], 1'b0);
    wait_idle();
    rd(2'd3, d);
  endtask

  task automatic t_tear();
    logic [7:0] d;
    select_chan(4'h3);
    wr(2'd0, 8'h00);
    wait_idle();
    rd(2'd2, d); check("R9 low ch3", d, 8'(exp_sample(4'h3)));
    select_chan(4'hC);
    wr(2'd0, 8'h00);
    wait_idle();
    rd(2'd3, d); check("R10 high held from first read", d, 8'(exp_sample(4'h3) >> 8));
    rd(2'd2, d); check("R10 new low", d, 8'(exp_sample(4'hC)));
    rd(2'd3, d); check("R10 new high", d, 8'(exp_sample(4'hC) >> 8));
  endtask

  task automatic t_ext();
    logic [7:0] d;
    int busy_n = 0;
    trig_sel = 2'd1;
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd1, d); check("R5 software ignored in external mode", d[7], 1'b0);
    ext_trig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2'd1, d); check("R4 not busy before third edge", d[7], 1'b0);
    rd(2'd1, d); check("R4 busy after third edge", d[7], 1'b1);
    busy_n = 1;
    for (int i = 0; i < 3 * CONV; i++) begin
      if (i == 6) ext_trig = 1'b0;
      rd(2'd1, d);
      if (d[7]) busy_n++;
    end
    check("R4 one conversion per pulse", 12'(busy_n), 12'(CONV));
    check("R8 long pulse no overrun", d[5], 1'b0);
    rd(2'd3, d);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    trig_sel = 2'd2;
    ext_trig = 1'b1;
    repeat (5) @(negedge clk);
    ext_trig = 1'b0;
    rd(2'd1, d); check("R5 external ignored in timer mode", d[7], 1'b0);
    timer_tick = 1'b1;
    @(negedge clk);
    timer_tick = 1'b0;
    rd(2'd1, d); check("R5 tick starts conversion", d[7], 1'b1);
    wait_idle();
    trig_sel = 2'd3;
    timer_tick = 1'b1;
    @(negedge clk);
    timer_tick = 1'b0;
    rd(2'd1, d); check("R5 no source selected", d, 8'h40);
  endtask

  task automatic t_data_writes();
    logic [7:0] d;
    rd(2'd2, d);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, d); check("R11 low unchanged", d, 8'(exp_sample(4'h5)));
    rd(2'd3, d); check("R11 high unchanged", d, 8'(exp_sample(4'h5) >> 8));
    wr(2'd0, 8'h01);
    rd(2'd1, d); check("R11 channel unchanged", d, 8'h05);
    wr(2'd0, 8'h00);
    rd(2'd1, d); check("R11 status unchanged", d, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    trig_sel = 2'd0; ext_trig = 1'b0; timer_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_channel();
    t_sw_conversion();
    t_overrun();
    t_tear();
    select_chan(4'h5);
    t_ext();
    t_timer();
    t_data_writes();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule